// File: doc/BRIEF.md
# Strobe-Timed Deferred Receive Status Register

This block is the status and receive-data face of a serial receiver that sits on a host bus with no clock. Every bus access is timed only by the active-low chip-select and read strobes. The receiver core runs on its own clock. It pulses `byte_done` when a byte has been assembled, and this sets a ready flag in the receiver clock domain.

A status read does not show the ready flag as it is at that moment. The trailing (rising) edge of each status read captures the flag into a strobe-domain register. The falling edge of the next status read moves that capture into an output register, which then drives the bus. A captured value therefore has the whole gap between two reads to settle, and the bus never carries a level that is still resolving. Software that needs the present state reads the status twice in a row.

A read of the data address returns the receiver byte. On its trailing edge it toggles a request line. A two-flop synchronizer carries that request into the receiver domain, where an edge detector turns it into a one-cycle clear of the flag.

The receiver-domain flag is a two-state machine:
- **FLAG_EMPTY** moves to **FLAG_FULL** on the SET transition (`byte_done` high).
- **FLAG_FULL** moves to **FLAG_EMPTY** on the CLEAR transition (synchronized clear pulse high while `byte_done` is low).
- If a SET and a clear pulse fall in the same cycle, the machine stays in or enters **FLAG_FULL**.

Top module: `deferred_status_reg`

## Requirements
- R1: After reset, the capture and output registers both hold 0. The first status read after reset returns 0x00 even if the flag is already set.
- R2: A status read returns the flag value sampled at the trailing edge of the previous status read, not the current flag.
- R3: Two status reads in a row return the current flag on the second read.
- R4: `bus_data` is driven only while `cs_n` and `rd_n` are both low. At all other times it is high-impedance.
- R5: The status byte carries the ready flag in bit 0, and bits 7..1 read as 0.
- R6: A `byte_done` pulse sets the flag on the next receiver clock edge. With no SET and no clear pulse, the flag holds its value.
- R7: A read of the data address (`addr` = 0) returns `rx_data`. The flag clears on the third receiver clock edge after that read's trailing edge.
- R8: A data read between two status reads leaves the captured status unchanged.
- R9: When `byte_done` and the synchronized clear fall on the same receiver edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rx_clk | input | 1 | Receiver-domain clock |
| byte_done | input | 1 | One-cycle pulse, in the `rx_clk` domain, when a byte completes |
| rx_data | input | DATA_W | Received byte shown on a data read |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe; its edges clock the bus-side registers |
| addr | input | ADDR_W | Register select: 1 = status, 0 = receive data |
| bus_data | inout | DATA_W | Tri-state host data bus |

## Verification
The flag is set one `rx_clk` edge after a `byte_done` sampled at a rising edge. A clear lands on the third rising `rx_clk` edge after the data read's trailing strobe edge. A status value reaches the bus only on the status read that follows its capture.

The bench drives every input on falling clock edges, and it places the strobe edges between rising edges. Before it samples the bus, which it does in the middle of the read-low window, it waits the whole number of cycles each path needs. The collision case puts `byte_done` on exactly the third edge after a data read, so a clear-wins design leaves the flag empty.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic {
        FLAG_EMPTY = 1'b0,
        FLAG_FULL  = 1'b1
    } flag_state_t;

    localparam logic STATUS_SEL = 1'b1;
    localparam logic DATA_SEL   = 1'b0;

endpackage

// File: rtl/dsr_flag_fsm.sv
module dsr_flag_fsm
    import dsr_pkg::*;
(
    input  logic rx_clk,
    input  logic rst_n,
    input  logic byte_done,
    input  logic clr_pulse,
    output logic flag
);

    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge rx_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_EMPTY: if (byte_done) state_d = FLAG_FULL;
            FLAG_FULL:  if (clr_pulse && !byte_done) state_d = FLAG_EMPTY;
            default:    state_d = FLAG_EMPTY;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_FULL);
    end

    AST_SET_WINS: assert property (@(posedge rx_clk) disable iff (!rst_n)
        byte_done |=> flag); // R9
    AST_CLEAR_TAKES: assert property (@(posedge rx_clk) disable iff (!rst_n)
        (clr_pulse && !byte_done) |=> !flag); // R7
    AST_FLAG_HOLDS: assert property (@(posedge rx_clk) disable iff (!rst_n)
        (!clr_pulse && !byte_done) |=> $stable(flag)); // R6
    AST_FALL_NEEDS_CLEAR: assert property (@(posedge rx_clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_pulse)); // R7

endmodule

// File: rtl/dsr_clear_sync.sv
module dsr_clear_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic rx_clk,
    input  logic rst_n,
    input  logic req_tog,
    output logic clr_pulse
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge rx_clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= req_tog;
        end
    end

    for (genvar g = 1; g < CHAIN_W; g++) begin : g_stage
        always_ff @(posedge rx_clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[g] <= 1'b0;
            end else begin
                chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign clr_pulse = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];

endmodule

// File: rtl/dsr_strobe_port.sv
module dsr_strobe_port
    import dsr_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              flag_in,
    output logic              status_bit,
    output logic              sel_status,
    output logic              req_tog
);

    logic cap_q;
    logic out_q;
    logic tog_q;
    logic sel_data;

    assign sel_status = (addr[0] == STATUS_SEL);
    assign sel_data   = (addr[0] == DATA_SEL);

    // trailing edge: sample the flag, or request a clear
    always_ff @(posedge rd_n or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            tog_q <= 1'b0;
        end else begin
            if (!cs_n && sel_status) cap_q <= flag_in;
            if (!cs_n && sel_data)   tog_q <= ~tog_q;
        end
    end

    // leading edge: present the earlier capture
    always_ff @(negedge rd_n or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (!cs_n && sel_status) begin
            out_q <= cap_q;
        end
    end

    assign status_bit = out_q;
    assign req_tog    = tog_q;

endmodule

// File: rtl/deferred_status_reg.sv
module deferred_status_reg
    import dsr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rst_n,
    input  logic              rx_clk,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] bus_data
);

    localparam int PAD_W = DATA_W - 1;

    logic              flag;
    logic              clr_pulse;
    logic              req_tog;
    logic              status_bit;
    logic              sel_status;
    logic [DATA_W-1:0] drive_val;
    logic              drive_en;

    dsr_flag_fsm u_flag (
        .rx_clk    (rx_clk),
        .rst_n     (rst_n),
        .byte_done (byte_done),
        .clr_pulse (clr_pulse),
        .flag      (flag)
    );

    dsr_clear_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .rx_clk    (rx_clk),
        .rst_n     (rst_n),
        .req_tog   (req_tog),
        .clr_pulse (clr_pulse)
    );

    dsr_strobe_port #(.ADDR_W(ADDR_W)) u_port (
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .addr       (addr),
        .flag_in    (flag),
        .status_bit (status_bit),
        .sel_status (sel_status),
        .req_tog    (req_tog)
    );

    always_comb begin
        drive_en  = !cs_n && !rd_n;
        drive_val = sel_status ? {{PAD_W{1'b0}}, status_bit} : rx_data;
    end

    assign bus_data = drive_en ? drive_val : {DATA_W{1'bz}};

endmodule

// File: tb/deferred_status_reg_bench.sv
`timescale 1ns/100ps
module deferred_status_reg_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       byte_done = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [0:0] addr = 1'b0;
    wire  [7:0] bus;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_pull
        pullup (bus[i]);
    end

    deferred_status_reg u_deferred_status_reg (
        .rst_n     (rst_n),
        .rx_clk    (clk),
        .byte_done (byte_done),
        .rx_data   (rx_data),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .addr      (addr),
        .bus_data  (bus)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic a, output logic [7:0] val);
        @(negedge clk);
        cs_n = 1'b0;
        addr = a;
        #1 rd_n = 1'b0;
        #1 val = bus;
        #1 rd_n = 1'b1;
        #0.5 cs_n = 1'b1;
    endtask

    task automatic pulse_byte();
        @(negedge clk);
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check8("R4 idle after reset", bus, 8'hFF);
        pulse_byte();
        idle(2);
        bus_read(1'b1, v);
        check8("R1 first status read", v, 8'h00);
        bus_read(1'b1, v);
        check8("R3 second read current", v, 8'h01);
        check8("R5 upper bits zero", v & 8'hFE, 8'h00);
    endtask

    task automatic t_deferred();
        logic [7:0] v;
        rx_data = 8'h3C;
        bus_read(1'b0, v);
        check8("R7 data value", v, 8'h3C);
        idle(6);
        bus_read(1'b1, v);
        check8("R8 stale capture after data read", v, 8'h01);
        bus_read(1'b1, v);
        check8("R7 flag cleared", v, 8'h00);
        pulse_byte();
        idle(2);
        bus_read(1'b1, v);
        check8("R2 deferred value", v, 8'h00);
        bus_read(1'b1, v);
        check8("R6 flag set", v, 8'h01);
        idle(10);
        bus_read(1'b1, v);
        check8("R6 flag held", v, 8'h01);
    endtask

    task automatic t_tristate();
        logic [7:0] v;
        @(negedge clk);
        addr = 1'b1;
        cs_n = 1'b0;
        #2 v = bus;
        cs_n = 1'b1;
        check8("R4 cs low rd high", v, 8'hFF);
        @(negedge clk);
        rd_n = 1'b0;
        #2 v = bus;
        rd_n = 1'b1;
        check8("R4 rd low cs high", v, 8'hFF);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        rx_data = 8'hA7;
        bus_read(1'b0, v);
        check8("R7 second data value", v, 8'hA7);
        @(negedge clk);
        @(negedge clk);
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
        idle(6);
        bus_read(1'b1, v);
        bus_read(1'b1, v);
        check8("R9 set wins over clear", v, 8'h01);
    endtask

    initial begin
        #2 rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_deferred();
        t_tristate();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule